// File: doc/BRIEF.md
# Multi-hop mesh routing unit

This block is the route-computation stage of a router in a two-dimensional mesh that also has longer links. Besides the four single-hop neighbours, a router may own straight links that skip two or three tiles and diagonal links that reach a corner tile in two hops. For every head flit the unit compares the router's own coordinate with the destination coordinate. From that comparison it raises request lines toward the output ports that bring the packet closer. The result is purely combinational from the addresses. Only the configuration that describes the local wiring and the turn policy is held in registers.

Each address is 8 bits: the low nibble is the X coordinate and the high nibble is the Y coordinate. East is increasing X and north is decreasing Y. The longest useful hop wins: any 3-hop request hides all 2-hop and 1-hop requests, and any 2-hop request hides the 1-hop requests. Every port has a connectivity bit that masks it. Eight turn bits decide which single-hop moves are allowed when the destination lies off both axes. When no minimal request survives, a per-input-port fallback selects one single-hop port. The decision runs through three named modes. MODE_LOCAL applies when the destination equals this router. MODE_MINIMAL applies when at least one minimal request exists. MODE_DEROUTE applies otherwise. There are no transitions between modes: each flit is classified on its own.

Top module: `mhr_route_unit`

## Requirements
- R1: With dx = dst.X - cur.X and dy = dst.Y - cur.Y (X is address bits 3:0, Y is bits 7:4, both unsigned), a k-hop flag (k = 1, 2, 3) is set as follows: east when dx >= k, west when dx <= -k, north when dy <= -k, south when dy >= k.
- R2: The 3-hop request vector req_hop3, with bit order {W,S,E,N} (N in bit 0), equals the 3-hop flags ANDed with connectivity bits 15:12.
- R3: req_hop2 bits 3:0 (NN,EE,SS,WW in bit order 0..3) are the 2-hop flags ANDed with connectivity bits 7:4. Bits 7:4 (NE,NW,SE,SW in bit order 4..7) are the paired 1-hop flags ANDed with connectivity bits 11:8. The whole vector is zero whenever any 3-hop request is set.
- R4: The single-hop candidates use the turn bits, numbered 0..7 as NE,NW,EN,ES,SE,SW,WN,WS. For example, the north candidate is N&E&turn[0], or N&W&turn[1], or N with neither E nor W. The other three directions are formed the same way, with their own pair of turn bits.
- R5: In MODE_MINIMAL, req_hop1 (bit order N,E,S,W) equals the candidates ANDed with connectivity bits 3:0, and it is zero whenever any 2-hop or 3-hop request is set.
- R6: No request bit is ever set while the connectivity bit of its port is clear.
- R7: In MODE_DEROUTE (not local, no minimal request), req_hop1 is the one-hot code of the 2-bit deroute entry of in_port (0=N,1=E,2=S,3=W), masked by that port's connectivity bit. Entry p lives in deroute bits 2p+1:2p, in_port 0..4 selects entries N,E,S,W,local, and in_port values 5..7 use the local entry.
- R8: When dst_addr equals cur_addr, req_local is 1 and every other request is 0. Otherwise req_local is 0.
- R9: A write with cfg_we high loads, at the clock edge, cfg_wdata[15:0] into connectivity for cfg_sel 0, cfg_wdata[7:0] into the turn bits for cfg_sel 1, and cfg_wdata[9:0] into the deroute entries for cfg_sel 2. cfg_sel 3 changes nothing.
- R10: An active-low asynchronous reset clears all connectivity, turn and deroute bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration group select |
| cfg_wdata | input | 16 | Configuration write data |
| cur_addr | input | 8 | This router's coordinate {Y,X} |
| dst_addr | input | 8 | Destination coordinate {Y,X} |
| in_port | input | 3 | Input port of the flit (0..4 = N,E,S,W,local) |
| req_local | output | 1 | Request to the local ejection port |
| req_hop1 | output | 4 | Single-hop requests N,E,S,W |
| req_hop2 | output | 8 | Two-hop requests NN,EE,SS,WW,NE,NW,SE,SW |
| req_hop3 | output | 4 | Three-hop requests N,E,S,W |

## Verification
Every destination address is swept against several router positions: a corner, the centre and off-centre points. Each sweep is repeated under six configurations. Full connectivity shows the hop priority, and a permissive turn set is contrasted with a closed one. A mask with only single-hop and diagonal links shows the 2-hop fallback without 3-hop shadowing. A mask with only long links and no single-hop ports shows that a blocked deroute yields no request, and sparse irregular masks push many flits into MODE_DEROUTE across all input-port entries. Directed vectors isolate the sign convention of each axis, the ignored select code and the clearing effect of reset.

// File: rtl/mhr_pkg.sv
package mhr_pkg;

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        SEL_CONN    = 2'd0,
        SEL_TURN    = 2'd1,
        SEL_DEROUTE = 2'd2,
        SEL_NONE    = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        MODE_LOCAL,
        MODE_MINIMAL,
        MODE_DEROUTE
    } route_mode_e;

    localparam int NUM_DIR  = 4;
    localparam int NUM_HOP  = 3;
    localparam int NUM_IN   = 5;
    localparam int CONN_W   = 16;
    localparam int TURN_W   = 8;
    localparam int DR_W     = 2 * NUM_IN;

    typedef logic [NUM_HOP-1:0][NUM_DIR-1:0] hop_flags_t;

endpackage

// File: rtl/mhr_cfg_regs.sv
module mhr_cfg_regs
    import mhr_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CONN_W-1:0]  conn_q,
    output logic [TURN_W-1:0]  turn_q,
    output logic [DR_W-1:0]    dr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conn_q <= '0;
            turn_q <= '0;
            dr_q   <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_CONN:    conn_q <= cfg_wdata[CONN_W-1:0];
                SEL_TURN:    turn_q <= cfg_wdata[TURN_W-1:0];
                SEL_DEROUTE: dr_q   <= cfg_wdata[DR_W-1:0];
                SEL_NONE:    ;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/mhr_dir_flags.sv
module mhr_dir_flags
    import mhr_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [2*CW-1:0] cur_addr,
    input  logic [2*CW-1:0] dst_addr,
    output hop_flags_t      flags,
    output logic            at_dest
);

    logic signed [CW:0] dx;
    logic signed [CW:0] dy;

    assign dx = $signed({1'b0, dst_addr[CW-1:0]})    - $signed({1'b0, cur_addr[CW-1:0]});
    assign dy = $signed({1'b0, dst_addr[2*CW-1:CW]}) - $signed({1'b0, cur_addr[2*CW-1:CW]});
    assign at_dest = (dst_addr == cur_addr);

    for (genvar h = 0; h < NUM_HOP; h++) begin : g_hop
        localparam logic signed [CW:0] DIST = (CW+1)'(h + 1);
        assign flags[h][DIR_E] = (dx >= DIST);
        assign flags[h][DIR_W] = (dx <= -DIST);
        assign flags[h][DIR_N] = (dy <= -DIST);
        assign flags[h][DIR_S] = (dy >= DIST);
    end

endmodule

// File: rtl/mhr_hop_select.sv
module mhr_hop_select
    import mhr_pkg::*;
(
    input  hop_flags_t          flags,
    input  logic                at_dest,
    input  logic [CONN_W-1:0]   conn,
    input  logic [TURN_W-1:0]   turn,
    input  logic [1:0]          dr_sel,
    output logic                req_local,
    output logic [3:0]          req_hop1,
    output logic [7:0]          req_hop2,
    output logic [3:0]          req_hop3
);

    logic [3:0] f1, f2, f3;
    logic [3:0] h3_min, h2_str, h2_dia, cand1, h1_min, dr_vec;
    logic       any3, any2, any1;
    route_mode_e mode;

    assign f1 = flags[0];
    assign f2 = flags[1];
    assign f3 = flags[2];

    assign h3_min = f3 & conn[15:12];
    assign any3   = |h3_min;

    assign h2_str = f2 & conn[7:4] & {4{~any3}};
    assign h2_dia = {f1[DIR_S] & f1[DIR_W],
                     f1[DIR_S] & f1[DIR_E],
                     f1[DIR_N] & f1[DIR_W],
                     f1[DIR_N] & f1[DIR_E]} & conn[11:8] & {4{~any3}};
    assign any2   = |{h2_str, h2_dia};

    assign cand1[DIR_N] = (f1[DIR_N] & f1[DIR_E] & turn[0]) | (f1[DIR_N] & f1[DIR_W] & turn[1])
                        | (f1[DIR_N] & ~f1[DIR_E] & ~f1[DIR_W]);
    assign cand1[DIR_E] = (f1[DIR_E] & f1[DIR_N] & turn[2]) | (f1[DIR_E] & f1[DIR_S] & turn[3])
                        | (f1[DIR_E] & ~f1[DIR_N] & ~f1[DIR_S]);
    assign cand1[DIR_S] = (f1[DIR_S] & f1[DIR_E] & turn[4]) | (f1[DIR_S] & f1[DIR_W] & turn[5])
                        | (f1[DIR_S] & ~f1[DIR_E] & ~f1[DIR_W]);
    assign cand1[DIR_W] = (f1[DIR_W] & f1[DIR_N] & turn[6]) | (f1[DIR_W] & f1[DIR_S] & turn[7])
                        | (f1[DIR_W] & ~f1[DIR_N] & ~f1[DIR_S]);

    assign h1_min = cand1 & conn[3:0] & {4{~(any3 | any2)}};
    assign any1   = |h1_min;
    assign dr_vec = (4'b0001 << dr_sel) & conn[3:0];

    always_comb begin
        if (at_dest)                   mode = MODE_LOCAL;
        else if (any3 | any2 | any1)   mode = MODE_MINIMAL;
        else                           mode = MODE_DEROUTE;
    end

    always_comb begin
        req_local = 1'b0;
        req_hop1  = '0;
        req_hop2  = '0;
        req_hop3  = '0;
        unique case (mode)
            MODE_LOCAL: req_local = 1'b1;
            MODE_MINIMAL: begin
                req_hop3 = h3_min;
                req_hop2 = {h2_dia, h2_str};
                req_hop1 = h1_min;
            end
            MODE_DEROUTE: req_hop1 = dr_vec;
            default: ;
        endcase
    end

endmodule

// File: rtl/mhr_route_unit.sv
module mhr_route_unit
    import mhr_pkg::*;
#(
    parameter int CW    = 4,
    parameter int CFG_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic [2*CW-1:0]     cur_addr,
    input  logic [2*CW-1:0]     dst_addr,
    input  logic [2:0]          in_port,
    output logic                req_local,
    output logic [3:0]          req_hop1,
    output logic [7:0]          req_hop2,
    output logic [3:0]          req_hop3
);

    localparam logic [2:0] LOCAL_IDX = 3'(NUM_IN - 1);

    logic [CONN_W-1:0] conn_q;
    logic [TURN_W-1:0] turn_q;
    logic [DR_W-1:0]   dr_q;
    hop_flags_t        flags;
    logic              at_dest;
    logic [2:0]        in_idx;
    logic [1:0]        dr_sel;

    mhr_cfg_regs #(.CFG_W(CFG_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .conn_q    (conn_q),
        .turn_q    (turn_q),
        .dr_q      (dr_q)
    );

    mhr_dir_flags #(.CW(CW)) flags_i (
        .cur_addr (cur_addr),
        .dst_addr (dst_addr),
        .flags    (flags),
        .at_dest  (at_dest)
    );

    assign in_idx = (in_port > LOCAL_IDX) ? LOCAL_IDX : in_port;
    assign dr_sel = dr_q[{in_idx, 1'b0} +: 2];

    mhr_hop_select sel_i (
        .flags     (flags),
        .at_dest   (at_dest),
        .conn      (conn_q),
        .turn      (turn_q),
        .dr_sel    (dr_sel),
        .req_local (req_local),
        .req_hop1  (req_hop1),
        .req_hop2  (req_hop2),
        .req_hop3  (req_hop3)
    );

endmodule

// File: rtl/mhr_route_checker.sv
module mhr_route_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [1:0]  cfg_sel,
    input logic [15:0] cfg_wdata,
    input logic        req_local,
    input logic [3:0]  req_hop1,
    input logic [7:0]  req_hop2,
    input logic [3:0]  req_hop3,
    input logic [15:0] conn_q,
    input logic [7:0]  turn_q,
    input logic [9:0]  dr_q
);

    p_local_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_local |-> (req_hop1 == 4'd0 && req_hop2 == 8'd0 && req_hop3 == 4'd0));

    p_hop3_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hop3 != 4'd0) |-> (req_hop2 == 8'd0 && req_hop1 == 4'd0));

    p_hop2_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hop2 != 8'd0) |-> (req_hop1 == 4'd0));

    p_conn_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_hop1 & ~conn_q[3:0]) == 4'd0) && ((req_hop2 & ~conn_q[11:4]) == 8'd0)
        && ((req_hop3 & ~conn_q[15:12]) == 4'd0));

    p_deroute_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hop2 == 8'd0 && req_hop3 == 4'd0) |-> $onehot0(req_hop1) || $countones(req_hop1) == 2);

    p_turn_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd1) |=> (turn_q == $past(cfg_wdata[7:0])));

    p_sel_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd3) |=> ($stable(conn_q) && $stable(turn_q) && $stable(dr_q)));

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (conn_q == 16'd0 && turn_q == 8'd0 && dr_q == 10'd0));

endmodule

bind mhr_route_unit mhr_route_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .req_local (req_local),
    .req_hop1  (req_hop1),
    .req_hop2  (req_hop2),
    .req_hop3  (req_hop3),
    .conn_q    (conn_q),
    .turn_q    (turn_q),
    .dr_q      (dr_q)
);

// File: tb/mhr_route_unit_tb_top.sv
`timescale 1ns/1ps
module mhr_route_unit_tb_top;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [7:0]  cur_addr = 8'd0;
    logic [7:0]  dst_addr = 8'd0;
    logic [2:0]  in_port = 3'd0;
    logic        req_local;
    logic [3:0]  req_hop1;
    logic [7:0]  req_hop2;
    logic [3:0]  req_hop3;

    logic [15:0] m_conn = 16'd0;
    logic [7:0]  m_turn = 8'd0;
    logic [9:0]  m_dr = 10'd0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_NS/2.0) clk = ~clk;

    mhr_route_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cur_addr(cur_addr), .dst_addr(dst_addr), .in_port(in_port),
        .req_local(req_local), .req_hop1(req_hop1), .req_hop2(req_hop2), .req_hop3(req_hop3)
    );

    // Expected {local, hop3, hop2, hop1} from the requirements R1..R8.
    function automatic logic [16:0] model(input int cur, input int dst, input int inp,
                                          input logic [15:0] c, input logic [7:0] t,
                                          input logic [9:0] dr);
        int dx, dy, ent, sel;
        logic [3:0] f1, f2, f3, h3, h1, cand, s2, d2;
        dx = (dst & 15) - (cur & 15);
        dy = ((dst >> 4) & 15) - ((cur >> 4) & 15);
        if (cur == dst) return {1'b1, 16'd0};
        f1 = {dx <= -1, dy >= 1, dx >= 1, dy <= -1};
        f2 = {dx <= -2, dy >= 2, dx >= 2, dy <= -2};
        f3 = {dx <= -3, dy >= 3, dx >= 3, dy <= -3};
        h3 = f3 & c[15:12];
        s2 = (h3 != 0) ? 4'd0 : (f2 & c[7:4]);
        d2 = (h3 != 0) ? 4'd0 : ({f1[2]&f1[3], f1[2]&f1[1], f1[0]&f1[3], f1[0]&f1[1]} & c[11:8]);
        cand[0] = f1[0] & ((f1[1] & t[0]) | (f1[3] & t[1]) | (!f1[1] & !f1[3]));
        cand[1] = f1[1] & ((f1[0] & t[2]) | (f1[2] & t[3]) | (!f1[0] & !f1[2]));
        cand[2] = f1[2] & ((f1[1] & t[4]) | (f1[3] & t[5]) | (!f1[1] & !f1[3]));
        cand[3] = f1[3] & ((f1[0] & t[6]) | (f1[2] & t[7]) | (!f1[0] & !f1[2]));
        h1 = (h3 != 0 || s2 != 0 || d2 != 0) ? 4'd0 : (cand & c[3:0]);
        if (h3 == 0 && s2 == 0 && d2 == 0 && h1 == 0) begin
            ent = (inp > 4) ? 4 : inp;
            sel = (dr >> (2 * ent)) & 3;
            h1 = (4'd1 << sel) & c[3:0];
        end
        return {1'b0, h3, d2, s2, h1};
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) m_conn = data;
        else if (sel == 2'd1) m_turn = data[7:0];
        else if (sel == 2'd2) m_dr = data[9:0];
    endtask

    task automatic probe(input int cur, input int dst, input int inp, input string tag);
        logic [16:0] exp, act;
        @(negedge clk);
        cur_addr = 8'(cur); dst_addr = 8'(dst); in_port = 3'(inp);
        #1;
        exp = model(cur, dst, inp, m_conn, m_turn, m_dr);
        act = {req_local, req_hop3, req_hop2, req_hop1};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cur=%02h dst=%02h in=%0d actual=%05h expected=%05h",
                     tag, cur, dst, inp, act, exp);
        end
    endtask

    initial begin
        logic [15:0] cfg_conn [6];
        logic [7:0]  cfg_turn [6];
        logic [9:0]  cfg_dr   [6];
        int          curs     [5];
        cfg_conn = '{16'hFFFF, 16'hFFFF, 16'h0F0F, 16'h000F, 16'hF0F0, 16'h3C96};
        cfg_turn = '{8'hFF, 8'h00, 8'h5A, 8'hA5, 8'hFF, 8'h3C};
        cfg_dr   = '{10'h000, 10'h1B4, 10'h2E4, 10'h3A6, 10'h0FF, 10'h159};
        curs     = '{8'h00, 8'h77, 8'h55, 8'hFF, 8'h3A};

        repeat (3) @(negedge clk);
        // R10: reset state, nothing configured, so no port is reachable
        probe(8'h55, 8'h00, 4, "R10 reset clears connectivity");
        probe(8'h55, 8'h55, 4, "R8 local after reset");
        rst_n = 1'b1;
        probe(8'h55, 8'h9C, 2, "R10 reset clears deroute");

        // R1/R2: sign convention of each axis, only one 3-hop link connected
        wr(2'd0, 16'h1000);
        probe(8'h50, 8'h20, 4, "R1 north is decreasing Y");
        probe(8'h20, 8'h50, 4, "R1 south masked R2");
        wr(2'd0, 16'h2000);
        probe(8'h00, 8'h03, 4, "R1 east is increasing X");
        probe(8'h03, 8'h00, 4, "R1 west masked R2");

        // R9: select code 3 is ignored
        wr(2'd3, 16'hFFFF);
        probe(8'h00, 8'h03, 4, "R9 ignored select");
        probe(8'h00, 8'h30, 4, "R9 ignored select");

        // R2..R8 sweeps
        for (int k = 0; k < 6; k++) begin
            wr(2'd0, cfg_conn[k]);
            wr(2'd1, {8'd0, cfg_turn[k]});
            wr(2'd2, {6'd0, cfg_dr[k]});
            for (int ci = 0; ci < 5; ci++)
                for (int d = 0; d < 256; d++)
                    probe(curs[ci], d, d % 8, "R2/R3/R4/R5/R6/R7/R8 sweep");
        end

        // R7: deroute with explicit entries and in_port beyond local
        wr(2'd0, 16'h000F);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h01E4);
        probe(8'h11, 8'h22, 0, "R7 deroute entry N");
        probe(8'h11, 8'h22, 3, "R7 deroute entry W");
        probe(8'h11, 8'h22, 6, "R7 deroute local entry");

        // R10: reset in mid-run clears all configuration
        @(negedge clk);
        rst_n = 1'b0;
        m_conn = '0; m_turn = '0; m_dr = '0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(8'h11, 8'h22, 0, "R10 mid-run reset");
        probe(8'h11, 8'h41, 4, "R10 mid-run reset");

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 200000.0);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule